// File: doc/BRIEF.md
# Per-Slot Control Bit Serializer

This block produces one serial control line that runs at the transmit bit rate. Each frame on the line is 256 bit periods long, which is 8 output streams times 32 channels. Every bit period carries one stored per-slot control flag. The flags live in a 256-entry table held outside this block, and the block reads that table through a single-bit lookup port. Writing and updating the table is not done here.

The line is built to run one channel ahead of the transmit data. This gives external gating logic a full channel period to act on a flag before its slot goes out. Within one channel period the eight bits are interleaved across the streams, stream 0 first and stream 7 last, rather than being sent as a byte for one stream. A frame pulse sets the position counter. After that the counter runs freely and wraps every 256 bits. A new pulse at any point moves it back to the start of the frame.

Top module: `ctl_serializer`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `ctl_out` is 0.
- R2: After reset, `ctl_out` stays 0 until a clock edge samples `frame_sync` high, whatever the table holds.
- R3: The clock edge that samples `frame_sync` high starts transmit position 0 (channel 0, first bit). From that edge on, `ctl_out` carries the flag of stream 0, channel 1. The table address is stream*32 + channel, so this is address 1.
- R4: Transmit position p = 8*n + k covers channel n and bit slot k, where k = 0 is the first bit sent. It carries the flag at address k*32 + ((n+1) mod 32).
- R5: The last channel period of a frame (positions 248 to 255) carries channel 0. Position 248 carries the flag at address 0 (stream 0, channel 0).
- R6: A stored 1 is driven high on `ctl_out` and a stored 0 is driven low.
- R7: With no further `frame_sync`, position 255 is followed by position 0 of the next frame, and the mapping of R4 repeats.
- R8: A `frame_sync` sampled in the middle of a frame restarts the sequence at position 0 on that edge.
- R9: A reset asserted during operation drives `ctl_out` to 0. The output stays 0 until the next `frame_sync`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one output bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame start; the edge that samples it high begins position 0 |
| rd_addr | output | 8 | Table address (stream*32 + channel) of the flag for the next bit |
| rd_data | input | 1 | Flag at `rd_addr`, returned in the same cycle |
| ctl_out | output | 1 | Registered serial control bit |

## Verification
Each output bit is due one clock edge after its address is presented. The table lookup adds no cycles, so the bit for position 0 is visible after the same edge that samples `frame_sync`. The bench drives inputs and samples `ctl_out` at falling edges. It raises `frame_sync` at one falling edge and checks position 0 at the next falling edge. It then checks position p at the p-th falling edge after that. Each expected value is taken from the bench's own copy of the table, using the channel-plus-one and stream-interleave mapping.

// File: rtl/ctlser_pkg.sv
package ctlser_pkg;
  localparam int DEF_STREAMS  = 8;
  localparam int DEF_CHANNELS = 32;
  localparam int DEF_LEAD     = 1;

  function automatic bit is_pow2(input int v);
    return (v > 0) && ((v & (v - 1)) == 0);
  endfunction
endpackage

// File: rtl/ctlser_slot_ctr.sv
module ctlser_slot_ctr #(
  parameter int N_STREAMS  = ctlser_pkg::DEF_STREAMS,
  parameter int N_CHANNELS = ctlser_pkg::DEF_CHANNELS,
  localparam int ST_W = $clog2(N_STREAMS),
  localparam int CH_W = $clog2(N_CHANNELS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_sync,
  output logic [ST_W-1:0] st_nxt,
  output logic [CH_W-1:0] ch_nxt,
  output logic            synced_q
);
  logic [ST_W-1:0] st_q;
  logic [CH_W-1:0] ch_q;
  logic            st_last;
  logic            ch_last;

  assign st_last = (st_q == ST_W'(N_STREAMS - 1));
  assign ch_last = (ch_q == CH_W'(N_CHANNELS - 1));

  // Position that the next edge will launch.
  always_comb begin
    if (frame_sync) begin
      st_nxt = '0;
      ch_nxt = '0;
    end else if (st_last) begin
      st_nxt = '0;
      ch_nxt = ch_last ? '0 : ch_q + 1'b1;
    end else begin
      st_nxt = st_q + 1'b1;
      ch_nxt = ch_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= '0;
      ch_q     <= '0;
      synced_q <= 1'b0;
    end else begin
      st_q <= st_nxt;
      ch_q <= ch_nxt;
      if (frame_sync) synced_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ctlser_addr_map.sv
module ctlser_addr_map #(
  parameter int N_STREAMS  = ctlser_pkg::DEF_STREAMS,
  parameter int N_CHANNELS = ctlser_pkg::DEF_CHANNELS,
  parameter int LEAD       = ctlser_pkg::DEF_LEAD,
  localparam int ST_W   = $clog2(N_STREAMS),
  localparam int CH_W   = $clog2(N_CHANNELS),
  localparam int ADDR_W = $clog2(N_STREAMS * N_CHANNELS)
) (
  input  logic [ST_W-1:0]   st,
  input  logic [CH_W-1:0]   ch,
  output logic [ADDR_W-1:0] addr
);
  logic [CH_W-1:0] ch_tgt;

  generate
    if (ctlser_pkg::is_pow2(N_CHANNELS) && ctlser_pkg::is_pow2(N_STREAMS)) begin : g_pow2
      // Channel wrap and stream placement fall out of bit widths.
      assign ch_tgt = ch + CH_W'(LEAD);
      assign addr   = {st, ch_tgt};
    end else begin : g_generic
      always_comb begin
        ch_tgt = CH_W'((int'(ch) + LEAD) % N_CHANNELS);
        addr   = ADDR_W'(int'(st) * N_CHANNELS + int'(ch_tgt));
      end
    end
  endgenerate
endmodule

// File: rtl/ctl_serializer.sv
module ctl_serializer #(
  parameter int N_STREAMS  = ctlser_pkg::DEF_STREAMS,
  parameter int N_CHANNELS = ctlser_pkg::DEF_CHANNELS,
  parameter int LEAD       = ctlser_pkg::DEF_LEAD,
  localparam int ST_W   = $clog2(N_STREAMS),
  localparam int CH_W   = $clog2(N_CHANNELS),
  localparam int ADDR_W = $clog2(N_STREAMS * N_CHANNELS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_sync,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_data,
  output logic              ctl_out
);
  logic [ST_W-1:0] st_nxt;
  logic [CH_W-1:0] ch_nxt;
  logic            synced_q;

  ctlser_slot_ctr #(
    .N_STREAMS (N_STREAMS),
    .N_CHANNELS(N_CHANNELS)
  ) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .frame_sync(frame_sync),
    .st_nxt    (st_nxt),
    .ch_nxt    (ch_nxt),
    .synced_q  (synced_q)
  );

  ctlser_addr_map #(
    .N_STREAMS (N_STREAMS),
    .N_CHANNELS(N_CHANNELS),
    .LEAD      (LEAD)
  ) u_map (
    .st  (st_nxt),
    .ch  (ch_nxt),
    .addr(rd_addr)
  );

  // Launch on the same edge as the transmit bit of that position.
  always_ff @(posedge clk) begin
    if (rst)                          ctl_out <= 1'b0;
    else if (synced_q || frame_sync)  ctl_out <= rd_data;
    else                              ctl_out <= 1'b0;
  end
endmodule

// File: rtl/ctlser_chk.sv
module ctlser_chk #(
  parameter int N_STREAMS  = 8,
  parameter int N_CHANNELS = 32,
  parameter int LEAD       = 1,
  localparam int ADDR_W = $clog2(N_STREAMS * N_CHANNELS)
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_sync,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_data,
  input logic              ctl_out
);
  logic              seen_q;
  logic [ADDR_W-1:0] prev_addr_q;
  logic [ADDR_W-1:0] exp_addr;
  int                pst, pch;

  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else if (frame_sync) seen_q <= 1'b1;
    prev_addr_q <= rd_addr;
  end

  always_comb begin
    pst = int'(prev_addr_q) / N_CHANNELS;
    pch = int'(prev_addr_q) % N_CHANNELS;
    if (pst == N_STREAMS - 1) exp_addr = ADDR_W'((pch + 1) % N_CHANNELS);
    else                      exp_addr = ADDR_W'((pst + 1) * N_CHANNELS + pch);
  end

  // R1
  out_low_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ctl_out == 1'b0);

  // R2
  low_before_sync_chk: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> ctl_out == 1'b0);

  // R3
  frame_start_addr_chk: assert property (@(posedge clk) disable iff (rst)
    frame_sync |-> rd_addr == ADDR_W'(LEAD % N_CHANNELS));

  // R4
  addr_progress_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !frame_sync) |-> rd_addr == exp_addr);

  // R6
  out_follows_data_chk: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> ctl_out == $past(rd_data));
endmodule

bind ctl_serializer ctlser_chk #(
  .N_STREAMS (N_STREAMS),
  .N_CHANNELS(N_CHANNELS),
  .LEAD      (LEAD)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .frame_sync(frame_sync),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data),
  .ctl_out   (ctl_out)
);

// File: tb/tb_ctl_serializer.sv
module tb_ctl_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NC = 32;
  localparam int NPOS = NS * NC;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_sync = 1'b0;
  logic [7:0] rd_addr;
  logic       rd_data;
  logic       ctl_out;
  logic       tbl [0:NPOS-1];

  int  vectors = 0;
  int  miscompares = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rd_data = tbl[rd_addr];

  ctl_serializer dut (
    .clk(clk), .rst(rst), .frame_sync(frame_sync),
    .rd_addr(rd_addr), .rd_data(rd_data), .ctl_out(ctl_out)
  );

  function automatic logic exp_bit(input int p);
    int n = p / NS;
    int k = p % NS;
    return tbl[k * NC + ((n + 1) % NC)];
  endfunction

  task automatic chk(input logic act, input logic exp, input string req, input int p);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s pos %0d: ctl_out=%b expected %b", req, p, act, exp);
    end
  endtask

  task automatic fill(input int kind);
    for (int i = 0; i < NPOS; i++) begin
      case (kind)
        0: tbl[i] = 1'b0;
        1: tbl[i] = 1'b1;
        2: tbl[i] = (i == 1);
        3: tbl[i] = (i == 0);
        default: tbl[i] = logic'(((i * 37) >> 3) & 1) ^ logic'(i & 1) ^ logic'((i >> 5) & 1);
      endcase
    end
  endtask

  // Raise the frame pulse for one cycle; returns at the falling edge where position 0 shows.
  task automatic pulse_sync();
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
  endtask

  task automatic t_reset();
    fill(1);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(ctl_out, 1'b0, "R1", -1);
    rst = 1'b0;
    @(negedge clk);
    chk(ctl_out, 1'b0, "R1", -1);
  endtask

  task automatic t_no_sync();
    fill(1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(ctl_out, 1'b0, "R2", -1);
    end
  endtask

  task automatic t_frame(input int kind, input int frames);
    string tag;
    fill(kind);
    @(negedge clk);
    pulse_sync();
    for (int p = 0; p < NPOS * frames; p++) begin
      if (p > 0) @(negedge clk);
      if (kind < 2)                tag = "R6";
      else if (p >= NPOS)          tag = "R7";
      else if (p == 0)             tag = "R3";
      else if (p % NPOS >= NPOS - NS) tag = "R5";
      else                         tag = "R4";
      chk(ctl_out, exp_bit(p % NPOS), tag, p % NPOS);
    end
  endtask

  task automatic t_realign();
    fill(4);
    @(negedge clk);
    pulse_sync();
    for (int p = 0; p < 100; p++) begin
      if (p > 0) @(negedge clk);
      chk(ctl_out, exp_bit(p), "R4", p);
    end
    pulse_sync();
    for (int p = 0; p < 24; p++) begin
      if (p > 0) @(negedge clk);
      chk(ctl_out, exp_bit(p), "R8", p);
    end
  endtask

  task automatic t_midreset();
    fill(1);
    @(negedge clk);
    pulse_sync();
    for (int p = 0; p < 5; p++) begin
      if (p > 0) @(negedge clk);
      chk(ctl_out, 1'b1, "R9", p);
    end
    rst = 1'b1;
    @(negedge clk);
    chk(ctl_out, 1'b0, "R9", -1);
    rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk(ctl_out, 1'b0, "R9", -1);
    end
  endtask

  initial begin
    t_reset();
    t_no_sync();
    t_frame(1, 1);
    t_frame(0, 1);
    t_frame(2, 1);
    t_frame(3, 1);
    t_frame(4, 2);
    t_realign();
    t_midreset();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule